// File: doc/BRIEF.md
# Burst Page-Mode Read Sequencer

This block drives the chip select, read strobe and byte address for reads from external page-mode or burst flash memory. A request carries a start address and a transfer size. The configured bus width, burst length and two wait counts are sampled when the request is accepted. If the transfer is wider than the bus, the block splits it into several bus beats. Those beats are grouped into bursts that never cross an aligned boundary set by the burst length.

Each burst begins with one first access. That access has an address setup cycle followed by a read strobe stretched by the first-access wait count. Page accesses follow, each stretched by the page wait count, and chip select stays low across all of them. Two flash helper outputs mark the start of each burst and each address advance inside a burst. Every beat's bus data is captured and returned with a valid pulse, and a done pulse marks the final beat.

Top module: `burst_read_seq`

## Requirements
- R1: While idle (`busy` low), `csN` and `rdN` are high and `flashStart` and `flashAdvance` are low. A request is accepted only while idle. `reqValid` raised while busy has no effect on the ongoing or any later sequence.
- R2: A first access is one cycle with `csN` low, `rdN` high and `flashStart` high, followed by `cfgFirstWait`+1 cycles with `csN` and `rdN` both low. Its total length is `cfgFirstWait`+2 cycles.
- R3: A page access lasts `cfgPageWait`+1 cycles with `csN` and `rdN` low throughout. `flashAdvance` is high only in its first cycle, which is the cycle in which the new address appears.
- R4: Transfer size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. Bus width codes are 0=8-bit, 1=16-bit, 2=32-bit, and 3 is treated as 32-bit. The beat count is the transfer bytes divided by the bus bytes, or 1 when the transfer is not wider than the bus.
- R5: Burst length codes are 0=1, 1=2, 2=4 and 3=8 beats. A burst ends after the beat whose bus-word index (address divided by the bus bytes) is the last one in its aligned group of that length. If beats remain, `csN` is high for exactly one cycle and a new first access begins.
- R6: With burst length 1, every beat is a first access, separated by one cycle with `csN` high.
- R7: With a 32-bit bus, burst length code 3 behaves as code 2 (4 beats).
- R8: The address starts at the request address and advances by the bus byte count. It changes only in the cycle after a beat's last cycle and stays unchanged after the final beat.
- R9: Bus data is captured in the last cycle of each beat. `beatValid` is high for exactly the next cycle, with the captured value on `beatData`.
- R10: `done` is high for one cycle together with the final `beatValid`, and `busy` is low in that same cycle.
- R11: Configuration inputs are sampled when the request is accepted. Changes while busy do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken while idle |
| reqAddr | input | AW | Start byte address |
| reqSize | input | 2 | Transfer size code |
| cfgBusWidth | input | 2 | Bus width code |
| cfgBurstLen | input | 2 | Burst length code |
| cfgFirstWait | input | 4 | First-access wait cycles |
| cfgPageWait | input | 4 | Page-access wait cycles |
| busData | input | DW | Read data from memory |
| busAddr | output | AW | Byte address to memory |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| flashStart | output | 1 | Burst start marker |
| flashAdvance | output | 1 | Address advance marker |
| beatValid | output | 1 | Captured beat valid |
| beatData | output | DW | Captured beat data |
| done | output | 1 | Final beat marker |
| busy | output | 1 | Sequence in progress |

## Verification
A request is accepted on the rising edge where `reqValid` is high and the block is idle. The setup cycle of the first access is visible from the next cycle on. After that, every output is due at a fixed cycle set by the two wait counts, the beat count and the boundary rule. `beatValid` and captured data are due one cycle after each beat's last strobe cycle, and `done` is due with the final one. The bench turns each request into one expected record per cycle and pushes those records when the request is accepted. It compares every output against the next record on each falling edge, so any early, late or missing transition is reported in the cycle it occurs.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FIRST,
    ST_PAGE,
    ST_GAP
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int MAX_BEATS_LOG = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic [1:0]    cfgBusWidth,
  input  logic [1:0]    cfgBurstLen,
  input  logic [DW-1:0] busData,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] beatData,
  output logic          beatValid,
  output logic          lastBeat,
  output logic          groupEnd
);
  localparam int CNT_W = MAX_BEATS_LOG + 1;

  logic [AW-1:0]    addrQ;
  logic [CNT_W-1:0] remQ;
  logic [1:0]       bwQ, lenQ;
  logic [DW-1:0]    dataQ;
  logic             validQ;

  logic [1:0]    bwIn, lenIn, beatsLogIn;
  logic [AW-1:0] wordIdx;
  logic [2:0]    lenMask;

  always_comb begin
    bwIn       = (cfgBusWidth == 2'd3) ? 2'd2 : cfgBusWidth;
    lenIn      = (bwIn == 2'd2 && cfgBurstLen == 2'd3) ? 2'd2 : cfgBurstLen;
    beatsLogIn = (reqSize > bwIn) ? (reqSize - bwIn) : 2'd0;
  end

  always_comb begin
    case (lenQ)
      2'd0:    lenMask = 3'b000;
      2'd1:    lenMask = 3'b001;
      2'd2:    lenMask = 3'b011;
      default: lenMask = 3'b111;
    endcase
    wordIdx  = addrQ >> bwQ;
    lastBeat = (remQ == CNT_W'(1));
    groupEnd = lastBeat || ((wordIdx[2:0] & lenMask) == lenMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      remQ  <= '0;
      bwQ   <= '0;
      lenQ  <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      remQ  <= CNT_W'(1) << beatsLogIn;
      bwQ   <= bwIn;
      lenQ  <= lenIn;
    end else if (strb.step) begin
      addrQ <= addrQ + (AW'(1) << bwQ);
      remQ  <= remQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.capture;
      if (strb.capture) dataQ <= busData;
    end
  end

  assign busAddr   = addrQ;
  assign beatData  = dataQ;
  assign beatValid = validQ;
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] cfgFirstWait,
  input  logic [3:0] cfgPageWait,
  input  logic       lastBeat,
  input  logic       groupEnd,
  output dpStrobe_t  strb,
  output logic       csN,
  output logic       rdN,
  output logic       flashStart,
  output logic       flashAdvance,
  output logic       done,
  output logic       busy
);
  seqState_e stateQ, stateD;
  logic [3:0] waitQ, waitD, firstWaitQ, pageWaitQ;
  logic       advQ, advD, doneQ;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    waitD  = waitQ;
    advD   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stateD    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        stateD = ST_FIRST;
        waitD  = firstWaitQ;
      end
      ST_FIRST, ST_PAGE: begin
        if (waitQ == 4'd0) begin
          strb.capture = 1'b1;
          if (lastBeat) begin
            stateD = ST_IDLE;
          end else begin
            strb.step = 1'b1;
            if (groupEnd) begin
              stateD = ST_GAP;
            end else begin
              stateD = ST_PAGE;
              waitD  = pageWaitQ;
              advD   = 1'b1;
            end
          end
        end else begin
          waitD = waitQ - 4'd1;
        end
      end
      ST_GAP:  stateD = ST_SETUP;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      waitQ      <= '0;
      advQ       <= 1'b0;
      doneQ      <= 1'b0;
      firstWaitQ <= '0;
      pageWaitQ  <= '0;
    end else begin
      stateQ <= stateD;
      waitQ  <= waitD;
      advQ   <= advD;
      doneQ  <= strb.capture && lastBeat;
      if (strb.load) begin
        firstWaitQ <= cfgFirstWait;
        pageWaitQ  <= cfgPageWait;
      end
    end
  end

  assign csN          = !(stateQ == ST_SETUP || stateQ == ST_FIRST || stateQ == ST_PAGE);
  assign rdN          = !(stateQ == ST_FIRST || stateQ == ST_PAGE);
  assign flashStart   = (stateQ == ST_SETUP);
  assign flashAdvance = advQ;
  assign done         = doneQ;
  assign busy         = (stateQ != ST_IDLE);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic [1:0]    cfgBusWidth,
  input  logic [1:0]    cfgBurstLen,
  input  logic [3:0]    cfgFirstWait,
  input  logic [3:0]    cfgPageWait,
  input  logic [DW-1:0] busData,
  output logic [AW-1:0] busAddr,
  output logic          csN,
  output logic          rdN,
  output logic          flashStart,
  output logic          flashAdvance,
  output logic          beatValid,
  output logic [DW-1:0] beatData,
  output logic          done,
  output logic          busy
);
  dpStrobe_t strb;
  logic      lastBeat, groupEnd;

  bseq_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .cfgFirstWait (cfgFirstWait),
    .cfgPageWait  (cfgPageWait),
    .lastBeat     (lastBeat),
    .groupEnd     (groupEnd),
    .strb         (strb),
    .csN          (csN),
    .rdN          (rdN),
    .flashStart   (flashStart),
    .flashAdvance (flashAdvance),
    .done         (done),
    .busy         (busy)
  );

  bseq_datapath #(.AW(AW), .DW(DW)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .cfgBusWidth (cfgBusWidth),
    .cfgBurstLen (cfgBurstLen),
    .busData     (busData),
    .busAddr     (busAddr),
    .beatData    (beatData),
    .beatValid   (beatValid),
    .lastBeat    (lastBeat),
    .groupEnd    (groupEnd)
  );
endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] busAddr,
  input logic          csN,
  input logic          rdN,
  input logic          flashStart,
  input logic          flashAdvance,
  input logic          beatValid,
  input logic          done,
  input logic          busy
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && rdN && !flashStart && !flashAdvance));

  a_r2_strobe_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !csN);

  a_r2_setup_shape: assert property (@(posedge clk) disable iff (!rstN)
    flashStart |-> (!csN && rdN));

  a_r2_setup_then_strobe: assert property (@(posedge clk) disable iff (!rstN)
    flashStart |=> (!rdN && !flashStart));

  a_r3_advance_moves_addr: assert property (@(posedge clk) disable iff (!rstN)
    flashAdvance |-> (!csN && !rdN && busAddr != $past(busAddr)));

  a_r8_addr_held_in_beat: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && $past(!rdN) && !flashAdvance) |-> $stable(busAddr));

  a_r5_gap_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (busy && csN) |=> flashStart);

  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> $past(!rdN));

  a_r10_done_with_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (beatValid && !busy));
endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .csN          (csN),
  .rdN          (rdN),
  .flashStart   (flashStart),
  .flashAdvance (flashAdvance),
  .beatValid    (beatValid),
  .done         (done),
  .busy         (busy)
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSize = '0, cfgBusWidth = '0, cfgBurstLen = '0;
  logic [3:0]    cfgFirstWait = '0, cfgPageWait = '0;
  logic [DW-1:0] busData;
  logic [AW-1:0] busAddr;
  logic          csN, rdN, flashStart, flashAdvance, beatValid, done, busy;
  logic [DW-1:0] beatData;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] memWord(logic [AW-1:0] a);
    return {a[15:0] ^ 16'hC35A, a[7:0], ~a[7:0]};
  endfunction

  assign busData = rdN ? '0 : memWord(busAddr);

  burst_read_seq #(.AW(AW), .DW(DW)) i_burst_read_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .cfgBusWidth(cfgBusWidth), .cfgBurstLen(cfgBurstLen),
    .cfgFirstWait(cfgFirstWait), .cfgPageWait(cfgPageWait), .busData(busData),
    .busAddr(busAddr), .csN(csN), .rdN(rdN), .flashStart(flashStart),
    .flashAdvance(flashAdvance), .beatValid(beatValid), .beatData(beatData),
    .done(done), .busy(busy)
  );

  typedef struct {
    logic          cs, rd, st, adv, val, dn, bsy;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  item_t         expQ[$];
  int            nChecks = 0;
  int            nFails  = 0;
  logic          pendV;
  logic [DW-1:0] pendD;

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put(logic cs, logic rd, logic st, logic adv, logic [AW-1:0] a);
    item_t it;
    it.cs = cs; it.rd = rd; it.st = st; it.adv = adv;
    it.val = pendV; it.data = pendD; it.dn = 1'b0; it.bsy = 1'b1; it.addr = a;
    expQ.push_back(it);
    pendV = 1'b0;
  endtask

  // driver: issues one request and pushes the expected per-cycle trace
  task automatic issue(int a, int sz, int bw, int ln, int fw, int pw);
    int bwE, lnE, n, mask;
    logic [AW-1:0] cur;
    bit newGroup;
    item_t fin;
    @(negedge clk);
    reqAddr = AW'(a); reqSize = 2'(sz); cfgBusWidth = 2'(bw); cfgBurstLen = 2'(ln);
    cfgFirstWait = 4'(fw); cfgPageWait = 4'(pw); reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    bwE  = (bw == 3) ? 2 : bw;
    lnE  = (bwE == 2 && ln == 3) ? 2 : ln;
    n    = (sz > bwE) ? (1 << (sz - bwE)) : 1;
    mask = (1 << lnE) - 1;
    cur  = AW'(a);
    newGroup = 1'b1;
    pendV = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (newGroup) begin
        if (i > 0) put(1, 1, 0, 0, cur);
        put(0, 1, 1, 0, cur);
        for (int k = 0; k <= fw; k++) put(0, 0, 0, 0, cur);
      end else begin
        for (int k = 0; k <= pw; k++) put(0, 0, 0, (k == 0), cur);
      end
      pendV = 1'b1;
      pendD = memWord(cur);
      if (i < n - 1) begin
        newGroup = (((int'(cur) >> bwE) & mask) == mask);
        cur = cur + AW'(1 << bwE);
      end
    end
    fin.cs = 1; fin.rd = 1; fin.st = 0; fin.adv = 0; fin.val = 1; fin.dn = 1;
    fin.bsy = 0; fin.addr = cur; fin.data = pendD;
    expQ.push_back(fin);
  endtask

  // monitor: compares one expected record per cycle
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      check(csN == e.cs, e.st ? "R2" : (e.adv ? "R3" : "R5"), "csN", DW'(csN), DW'(e.cs));
      check(rdN == e.rd, "R2", "rdN", DW'(rdN), DW'(e.rd));
      check(flashStart == e.st, "R2", "flashStart", DW'(flashStart), DW'(e.st));
      check(flashAdvance == e.adv, "R3", "flashAdvance", DW'(flashAdvance), DW'(e.adv));
      check(busAddr == e.addr, "R8", "busAddr", DW'(busAddr), DW'(e.addr));
      check(beatValid == e.val, "R9", "beatValid", DW'(beatValid), DW'(e.val));
      if (e.val) check(beatData == e.data, "R9", "beatData", beatData, e.data);
      check(done == e.dn, "R10", "done", DW'(done), DW'(e.dn));
      check(busy == e.bsy, "R10", "busy", DW'(busy), DW'(e.bsy));
    end
  end

  task automatic drain();
    wait (expQ.size() == 0);
    @(negedge clk);
    check(!busy && csN && rdN && !beatValid, "R1", "idle after sequence",
          DW'({busy, csN, rdN, beatValid}), DW'(4'b0110));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL R10 watchdog: actual busy=%0d expected sequence finished", busy);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN && rdN && !busy && !flashStart && !flashAdvance && !beatValid && !done,
          "R1", "reset outputs", DW'({csN, rdN, busy, beatValid, done}), DW'(5'b11000));
    rstN = 1'b1;
    @(negedge clk);

    issue(32'h100, 2, 0, 2, 2, 1); drain();   // R4 one 4-beat burst over 8-bit bus
    issue(32'h204, 2, 0, 1, 0, 0); drain();   // R5 two 2-beat bursts
    issue(32'h310, 2, 0, 0, 1, 0); drain();   // R6 single-access mode
    issue(32'h307, 1, 0, 3, 3, 2); drain();   // R5 unaligned start hits boundary
    issue(32'h00C, 3, 2, 3, 1, 1); drain();   // R7 clamp splits at 16-byte boundary
    issue(32'h010, 3, 2, 3, 0, 0); drain();   // R7 two beats in one group
    issue(32'h400, 3, 0, 3, 0, 3); drain();   // R3 eight-beat burst
    issue(32'h522, 1, 1, 2, 4, 0); drain();   // R4 transfer equals bus width
    issue(32'h600, 0, 2, 3, 0, 0); drain();   // R4 byte over 32-bit bus
    issue(32'h00C, 3, 3, 3, 0, 0); drain();   // R4 width code 3 as 32-bit, R7

    // R1 / R11: request and config changes while busy are ignored
    issue(32'h700, 2, 0, 2, 2, 1);
    repeat (2) @(negedge clk);
    reqValid = 1'b1; reqAddr = 24'hABC; cfgFirstWait = 4'd15; cfgPageWait = 4'd9;
    cfgBurstLen = 2'd0; cfgBusWidth = 2'd2; reqSize = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    check(csN && !busy && !flashStart, "R1", "no late start from ignored request",
          DW'({csN, busy, flashStart}), DW'(3'b100));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule